// File: doc/BRIEF.md
# Fuse-Programmable Sum-of-Products Array

This block is a two-level AND-OR logic array whose connections are held in a register of fuse bits. Five logic inputs enter the product plane in both true and inverted form, which gives ten literals. Seven product lines each take the AND of the literals whose fuse is intact. Three outputs each take the OR of the product lines whose fuse is intact. A fuse value of 1 means intact and 0 means blown. After reset every fuse is intact, as on a fresh device. In that state each product line contains some input together with its inverse, so every product is 0.

A two-bit mode input chooses which plane follows the fuses.
- In full mode both planes are programmable.
- In fixed-sum mode the product plane is programmable and each output ORs a fixed, contiguous group of product lines.
- In decoder mode each product line is a fixed minterm of the three low inputs, and the sum plane stays programmable.

One product line can feed several outputs. Fuse bits enter serially on the clock while a load enable is high. A done flag rises after the last fuse bit has been taken in.

Top module: `sop_fuse_array`

## Requirements
- R1: Synchronous active-high reset sets every fuse to intact (1), clears the load count and drives `cfg_done` low.
- R2: With every fuse intact, all outputs are 0 in full mode and in fixed-sum mode. In decoder mode output k is 1 exactly when `din[2:0]` is not 7.
- R3: On each rising clock edge with `cfg_en` high and `cfg_done` low, one fuse bit is taken from `cfg_bit`. When `cfg_en` is low the bit is ignored. The first 70 bits fill the product plane: term 0 first, and within a term, for input i from 0 to 4, the true literal of `din[i]` and then its inverse. The last 21 bits fill the sum plane: output 0 for terms 0 to 6, then output 1, then output 2. A 1 leaves the fuse intact and a 0 blows it.
- R4: `cfg_done` rises at the edge that takes the 91st bit and stays high. Once it is high, further bits are ignored until reset.
- R5: A product line is the AND of the literals whose fuse is intact. Blown literals play no part.
- R6: In full mode (`mode` 0, and also `mode` 3), output k is the OR of the product lines whose sum-plane fuse for k is intact. One product line may drive several outputs.
- R7: In fixed-sum mode (`mode` 1), the sum-plane fuses are unused. Output 0 ORs terms 0 to 2, output 1 ORs terms 3 and 4, and output 2 ORs terms 5 and 6.
- R8: In decoder mode (`mode` 2), product line t is 1 exactly when `din[2:0]` equals t, and the product-plane fuses are unused. With `din[2:0]` = 7 every output is 0.
- R9: In full mode and in decoder mode, an output whose sum-plane fuses are all blown is 0.
- R10: The outputs are combinational in `din` and `mode`. They follow an input change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset; restores all fuses to intact |
| cfg_en | input | 1 | Load enable for the serial fuse stream |
| cfg_bit | input | 1 | Serial fuse bit, 1 intact, 0 blown |
| mode | input | 2 | 0 full, 1 fixed-sum, 2 decoder, 3 full |
| din | input | 5 | Logic inputs; bit i is input i |
| dout | output | 3 | Sum outputs; bit k is output k |
| cfg_done | output | 1 | High once all 91 fuse bits are loaded |

## Verification
A hand-worked table of eight input words, then a sweep of all 32 input words, is applied under a configuration with three equations and seven terms. Here term 0 is shared by outputs 0 and 2, so the sweep shows whether one term drives two sums and whether each literal landed in its bit position. The same fuse image is swept in fixed-sum mode, where output 2 loses the shared term, and in decoder mode, where the outputs depend only on `din[2:0]`. These three sweeps separate the three mode paths. A second image with one output's sum fuses all blown, a load stream with ignored gap bits, surplus bits after done, and the all-intact reset state cover the remaining corners.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEF_N_IN   = 5;
    localparam int DEF_N_TERM = 7;
    localparam int DEF_N_OUT  = 3;

    typedef enum logic [1:0] {
        MODE_PLA     = 2'd0,
        MODE_PAL     = 2'd1,
        MODE_PROM    = 2'd2,
        MODE_PLA_ALT = 2'd3
    } mode_e;

    // Output that owns term t when the sum plane is fixed: terms are split
    // into contiguous groups, the first (n_term % n_out) groups one larger.
    function automatic int pal_owner(input int t, input int n_term, input int n_out);
        int base;
        int rem;
        int big;
        base = n_term / n_out;
        rem  = n_term % n_out;
        big  = rem * (base + 1);
        if (t < big)
            return t / (base + 1);
        return rem + (t - big) / base;
    endfunction
endpackage

// File: rtl/sfa_fuse_loader.sv
module sfa_fuse_loader #(
    parameter int TOTAL = 91
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic [TOTAL-1:0] fuse_q,
    output logic             done
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt;
    logic          take;

    assign take = cfg_en && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_q <= '1;
            cnt    <= '0;
            done   <= 1'b0;
        end else if (take) begin
            fuse_q <= {fuse_q[TOTAL-2:0], cfg_bit};
            cnt    <= cnt + 1'b1;
            done   <= (cnt == CW'(TOTAL - 1));
        end
    end
endmodule

// File: rtl/sfa_and_plane.sv
module sfa_and_plane
    import sfa_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_TERM = DEF_N_TERM
) (
    input  mode_e                      mode,
    input  logic [N_IN-1:0]            din,
    input  logic [N_TERM*2*N_IN-1:0]   and_fuse,
    output logic [N_TERM-1:0]          prod
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_LIT    = 2 * N_IN;
    localparam int AND_BITS = N_TERM * N_LIT;
    localparam int SEL_W    = (N_TERM > 1) ? $clog2(N_TERM) : 1;

    logic [N_LIT-1:0] lits;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lits[2*i]   = din[i];
            lits[2*i+1] = ~din[i];
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_LIT-1:0] keep;
        logic             fused_term;
        logic             decoded_term;

        always_comb begin
            for (int l = 0; l < N_LIT; l++)
                keep[l] = and_fuse[AND_BITS-1-(t*N_LIT+l)];
        end

        // a blown fuse turns its literal into a don't-care
        assign fused_term   = &(lits | ~keep);
        assign decoded_term = (din[SEL_W-1:0] == SEL_W'(t));
        assign prod[t]      = (mode == MODE_PROM) ? decoded_term : fused_term;
    end
endmodule

// File: rtl/sfa_or_plane.sv
module sfa_or_plane
    import sfa_pkg::*;
#(
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_OUT  = DEF_N_OUT
) (
    input  mode_e                      mode,
    input  logic [N_TERM-1:0]          prod,
    input  logic [N_TERM*N_OUT-1:0]    or_fuse,
    output logic [N_OUT-1:0]           dout
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int OR_BITS = N_TERM * N_OUT;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [N_TERM-1:0] conn;
        logic [N_TERM-1:0] fixed_grp;

        always_comb begin
            for (int t = 0; t < N_TERM; t++) begin
                conn[t]      = or_fuse[OR_BITS-1-(k*N_TERM+t)];
                fixed_grp[t] = (pal_owner(t, N_TERM, N_OUT) == k);
            end
        end

        assign dout[k] = |(prod & ((mode == MODE_PAL) ? fixed_grp : conn));
    end
endmodule

// File: rtl/sop_fuse_array.sv
module sop_fuse_array
    import sfa_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_OUT  = DEF_N_OUT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [1:0]       mode,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout,
    output logic             cfg_done
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_LIT     = 2 * N_IN;
    localparam int AND_BITS  = N_TERM * N_LIT;
    localparam int OR_BITS   = N_TERM * N_OUT;
    localparam int FUSE_BITS = AND_BITS + OR_BITS;

    logic [FUSE_BITS-1:0] fuse_q;
    logic [N_TERM-1:0]    prod;
    mode_e                mode_sel;

    assign mode_sel = mode_e'(mode);

    sfa_fuse_loader #(.TOTAL(FUSE_BITS)) u_loader (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .fuse_q  (fuse_q),
        .done    (cfg_done)
    );

    sfa_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .mode     (mode_sel),
        .din      (din),
        .and_fuse (fuse_q[FUSE_BITS-1 -: AND_BITS]),
        .prod     (prod)
    );

    sfa_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .mode    (mode_sel),
        .prod    (prod),
        .or_fuse (fuse_q[OR_BITS-1:0]),
        .dout    (dout)
    );
endmodule

// File: rtl/sop_fuse_array_chk.sv
module sop_fuse_array_chk #(
    parameter int N_IN   = 5,
    parameter int N_TERM = 7,
    parameter int N_OUT  = 3
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 cfg_en,
    input logic                                 cfg_done,
    input logic [1:0]                           mode,
    input logic [((N_TERM>1)?$clog2(N_TERM):1)-1:0] din_lo,
    input logic [N_OUT-1:0]                     dout,
    input logic [N_TERM*(2*N_IN+N_OUT)-1:0]     fuse_q
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AND_BITS  = N_TERM * 2 * N_IN;
    localparam int OR_BITS   = N_TERM * N_OUT;
    localparam int FUSE_BITS = AND_BITS + OR_BITS;

    assert_reset_done_low_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cfg_done)
        else $error("R1: cfg_done high right after reset");

    assert_unprog_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ((mode != 2'd2) && (&fuse_q[FUSE_BITS-1 -: AND_BITS])) |-> (dout == '0))
        else $error("R2: output high with all product fuses intact");

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_en)) |-> $stable(fuse_q))
        else $error("R3: fuses changed without load enable");

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done)
        else $error("R4: cfg_done dropped");

    assert_done_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_done) |-> $past(cfg_en))
        else $error("R4: cfg_done rose without an accepted bit");

    assert_prom_unused_R8: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'd2) && (int'(din_lo) >= N_TERM)) |-> (dout == '0))
        else $error("R8: decoder mode output on an unused minterm");

    for (genvar k = 0; k < N_OUT; k++) begin : g_out_chk
        assert_blown_or_zero_R9: assert property (@(posedge clk) disable iff (rst)
            ((mode != 2'd1) && (fuse_q[OR_BITS-1-k*N_TERM -: N_TERM] == '0)) |-> !dout[k])
            else $error("R9: output with all sum fuses blown is high");
    end
endmodule

bind sop_fuse_array sop_fuse_array_chk #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_done (cfg_done),
    .mode     (mode),
    .din_lo   (din[((N_TERM>1)?$clog2(N_TERM):1)-1:0]),
    .dout     (dout),
    .fuse_q   (fuse_q)
);

// File: tb/tb_sop_fuse_array.sv
module tb_sop_fuse_array;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NI = 5;
    localparam int NT = 7;
    localparam int NO = 3;
    localparam int NBITS = NT * (2 * NI + NO);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [4:0] din = '0;
    logic [2:0] dout;
    logic       cfg_done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sop_fuse_array dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .mode(mode), .din(din), .dout(dout), .cfg_done(cfg_done)
    );

    // Term literals, din[4]..din[0] standing for the five variables (first
    // variable on din[4]). USE marks a literal, POL 1 = true, 0 = inverted.
    localparam logic [4:0] USE [NT] = '{5'b11010, 5'b01110, 5'b11111, 5'b11001,
                                         5'b01111, 5'b01111, 5'b11110};
    localparam logic [4:0] POL [NT] = '{5'b00000, 5'b00100, 5'b01110, 5'b01001,
                                         5'b00101, 5'b00001, 5'b01110};
    localparam logic [6:0] OR_REF [NO] = '{7'h07, 7'h18, 7'h61};
    localparam logic [6:0] OR_ONE_BLOWN [NO] = '{7'h07, 7'h00, 7'h61};
    localparam logic [6:0] PAL_GRP [NO] = '{7'h07, 7'h18, 7'h60};
    // {din, expected dout} worked by hand from the three equations
    localparam logic [7:0] VEC [8] = '{
        {5'b00000, 3'b101}, {5'b00101, 3'b111}, {5'b01101, 3'b010},
        {5'b01110, 3'b101}, {5'b01111, 3'b110}, {5'b10001, 3'b100},
        {5'b11111, 3'b000}, {5'b10100, 3'b001}};

    function automatic logic [6:0] terms_fused(input logic [4:0] d);
        logic [6:0] r;
        for (int t = 0; t < NT; t++)
            r[t] = &((d ~^ POL[t]) | ~USE[t]);
        return r;
    endfunction

    function automatic logic [6:0] terms_prom(input logic [4:0] d);
        logic [6:0] r;
        for (int t = 0; t < NT; t++)
            r[t] = (d[2:0] == 3'(t));
        return r;
    endfunction

    function automatic logic [2:0] expect_out(input logic [4:0] d, input logic [1:0] md,
                                              input logic [6:0] orm [NO]);
        logic [6:0] p;
        logic [2:0] r;
        p = (md == 2'd2) ? terms_prom(d) : terms_fused(d);
        for (int k = 0; k < NO; k++)
            r[k] = |(p & ((md == 2'd1) ? PAL_GRP[k] : orm[k]));
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cfg_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_bit(input logic b, input bit gap);
        if (gap) begin
            cfg_en = 1'b0;
            cfg_bit = ~b;
            @(posedge clk);
            @(negedge clk);
        end
        cfg_en = 1'b1;
        cfg_bit = b;
        @(posedge clk);
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic load(input logic [6:0] orm [NO], input bit gap);
        logic [NBITS-1:0] s;
        int j;
        j = NBITS - 1;
        for (int t = 0; t < NT; t++) begin
            for (int i = 0; i < NI; i++) begin
                s[j] = USE[t][i] & POL[t][i];  j--;
                s[j] = USE[t][i] & ~POL[t][i]; j--;
            end
        end
        for (int k = 0; k < NO; k++)
            for (int t = 0; t < NT; t++) begin
                s[j] = orm[k][t]; j--;
            end
        for (int b = NBITS - 1; b >= 0; b--) begin
            if (b == 0) chk("R4 done low after 90 bits", {7'b0, cfg_done}, 8'h00);
            push_bit(s[b], gap);
        end
        chk("R4 done high after 91 bits", {7'b0, cfg_done}, 8'h01);
    endtask

    task automatic sweep(input logic [1:0] md, input logic [6:0] orm [NO], input string tag);
        mode = md;
        for (int d = 0; d < 32; d++) begin
            @(negedge clk);
            din = 5'(d);
            #1;
            chk(tag, {5'b0, dout}, {5'b0, expect_out(din, md, orm)});
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 cfg_done low after reset", {7'b0, cfg_done}, 8'h00);

        // R2: fresh device, every fuse intact
        for (int m = 0; m < 3; m++) begin
            mode = 2'(m);
            for (int d = 0; d < 32; d++) begin
                @(negedge clk);
                din = 5'(d);
                #1;
                if (m == 2)
                    chk("R2 unprogrammed decoder", {5'b0, dout},
                        (din[2:0] != 3'd7) ? 8'h07 : 8'h00);
                else
                    chk("R2 unprogrammed all zero", {5'b0, dout}, 8'h00);
            end
        end

        // R3: reference image with ignored gap bits between real ones
        load(OR_REF, 1'b1);

        mode = 2'd0;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            din = VEC[v][7:3];
            #1;
            chk("R6 table vector", {5'b0, dout}, {5'b0, VEC[v][2:0]});
        end

        // R10: output follows din with no clock edge in between
        @(negedge clk);
        din = 5'b00000;
        #1;
        chk("R10 comb first", {5'b0, dout}, 8'h05);
        din = 5'b01101;
        #1;
        chk("R10 comb second", {5'b0, dout}, 8'h02);

        sweep(2'd0, OR_REF, "R3 R5 R6 full mode sweep");
        sweep(2'd1, OR_REF, "R7 fixed-sum sweep");
        sweep(2'd2, OR_REF, "R8 decoder sweep");
        sweep(2'd3, OR_REF, "R6 mode 3 as full");

        // R4: surplus bits after done must not alter any fuse
        for (int e = 0; e < 5; e++) push_bit(1'b0, 1'b0);
        chk("R4 done stays high", {7'b0, cfg_done}, 8'h01);
        sweep(2'd0, OR_REF, "R4 surplus bits ignored");

        // R1 again, then R9 image with output 1 fully blown
        do_reset();
        chk("R1 done cleared on reset", {7'b0, cfg_done}, 8'h00);
        mode = 2'd0;
        din = 5'b00000;
        #1;
        chk("R1 fuses restored intact", {5'b0, dout}, 8'h00);
        load(OR_ONE_BLOWN, 1'b0);
        sweep(2'd0, OR_ONE_BLOWN, "R9 full mode blown output");
        sweep(2'd2, OR_ONE_BLOWN, "R9 decoder blown output");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule